// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a configurable AND-OR plane of the kind found in registered programmable array logic. Twenty-two signals reach the plane: twelve dedicated inputs and ten feedback paths that come back from the output pins. Each signal is offered in true and complement form, so the plane has 44 literal columns. Every product-term row has one configuration bit per column that decides whether that literal takes part in the row's AND. Each row also has one disable bit that forces the row to 0.

The summed rows are dealt out to ten OR sums in unequal groups. The group sizes run 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 from output 0 to output 9, which gives 120 summed rows. Two further rows are not summed and come out on their own pins. A surrounding macrocell can use them as its global clear and preset terms.

The configuration is held in one serial shift chain that is loaded while a shift enable is high. Once the chain is loaded, the plane is purely combinational from the inputs to the sums. Output registers, output polarity and tri-state control belong to the surrounding logic.

Top module: `pal_sop_array`

## Requirements
- R1: While reset is low the configuration chain is cleared. After reset every row is therefore empty and enabled, so sum_out is 10'h3FF and clr_term and set_term are 1.
- R2: On each rising clock edge with cfg_shift_en high, cfg_sdi enters the top bit of the chain and every bit moves down by one. After a full load of 5490 shifts, the first bit shifted in sits at chain bit 0. Row r occupies chain bits r*45 to r*45+44.
- R3: With cfg_shift_en low the chain keeps its contents whatever cfg_sdi does, so the outputs keep following the loaded pattern.
- R4: Within a row, bit 2*s connects the true literal of signal s and bit 2*s+1 connects its complement; bit value 1 means connected. Signals 0 to 11 are in_ded[0..11] and signals 12 to 21 are in_fb[0..9]. A row is the AND of its connected literals.
- R5: An enabled row with no connected literal evaluates to 1.
- R6: A row that connects both the true and the complement literal of any one signal evaluates to 0.
- R7: A row whose bit 44 (disable) is 1 evaluates to 0 and adds nothing to its sum.
- R8: sum_out[k] is the OR of a contiguous group of rows taken in output order with sizes 8,10,12,14,16,16,14,12,10,8. Output 0 uses rows 0 to 7, output 2 ends at row 29, and output 9 ends at row 119.
- R9: Row 120 drives clr_term and row 121 drives set_term, and neither row feeds any sum.
- R10: With the chain idle, the outputs follow changes on in_ded and in_fb within the same cycle without a clock edge, and they stay steady while those inputs stay steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, clears the chain |
| cfg_shift_en | input | 1 | Shift enable for the configuration chain |
| cfg_sdi | input | 1 | Serial configuration data |
| in_ded | input | 12 | Dedicated inputs, signals 0 to 11 |
| in_fb | input | 10 | Feedback inputs, signals 12 to 21 |
| sum_out | output | 10 | One OR sum per output |
| clr_term | output | 1 | Unsummed product term for global clear |
| set_term | output | 1 | Unsummed product term for preset |

## Verification
The directed pattern places enabled empty rows at the first row of output 0, the last row of output 2 and the last row of output 9. A design with a group boundary off by one would light a neighbouring output or drop one of these. A contradictory row at the very end of output 5 targets a design that lets a true/complement pair cancel out instead of forcing 0. A separate pattern with every row disabled catches a disable bit that is ignored. The two unsummed rows are tied to single literals on opposite ends of the signal range, which exposes swapped clear/preset rows or a reversed literal order. Random patterns of varying density, followed by an idle stretch where cfg_sdi toggles, catch chain corruption while the chain is not enabled.

// File: rtl/pal_sop_pkg.sv
package pal_sop_pkg;

  // Rows given to output k: a minimum plus a step per position away from
  // the nearer end, so the sizes are symmetric about the centre.
  function automatic int group_terms(input int k, input int n_out,
                                     input int min_t, input int step);
    int d;
    d = (k < (n_out - 1 - k)) ? k : (n_out - 1 - k);
    return min_t + step * d;
  endfunction

  // First row of output k (also the total summed rows when k == n_out).
  function automatic int group_base(input int k, input int n_out,
                                    input int min_t, input int step);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += group_terms(j, n_out, min_t, step);
    return acc;
  endfunction

endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           sdi,
  output logic [LEN-1:0] bits
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else if (shift_en) bits <= {sdi, bits[LEN-1:1]};
  end

  // R2: new bit enters at the top, the rest move down by one
  assert_shift_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (bits[LEN-1] == $past(sdi)));
  assert_shift_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (bits[LEN-2:0] == $past(bits[LEN-1:1])));
  // R3: idle chain holds
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(bits));

endmodule

// File: rtl/pal_pterm.sv
module pal_pterm #(
  parameter int N_SIG = 22
) (
  input  logic [N_SIG-1:0]   sig,
  input  logic [2*N_SIG-1:0] conn,
  input  logic               dis,
  output logic               term,
  output logic               contra,
  output logic               empty
);

  logic [2*N_SIG-1:0] lit;
  logic [N_SIG-1:0]   conn_t;
  logic [N_SIG-1:0]   conn_c;

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[2*s]   = sig[s];
    assign lit[2*s+1] = ~sig[s];
    assign conn_t[s]  = conn[2*s];
    assign conn_c[s]  = conn[2*s+1];
  end

  // Unconnected columns pass 1 into the AND; a disabled row is 0.
  assign term   = ~dis & (&(~conn | lit));
  // Event wires for the checks in the top level.
  assign contra = |(conn_t & conn_c);
  assign empty  = ~|conn;

endmodule

// File: rtl/pal_or_group.sv
module pal_or_group #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] terms,
  output logic             sum
);

  assign sum = |terms;

endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array
  import pal_sop_pkg::*;
#(
  parameter int N_DED     = 12,
  parameter int N_FB      = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_shift_en,
  input  logic            cfg_sdi,
  input  logic [N_DED-1:0] in_ded,
  input  logic [N_FB-1:0]  in_fb,
  output logic [N_FB-1:0]  sum_out,
  output logic            clr_term,
  output logic            set_term
);

  localparam int N_OUT      = N_FB;
  localparam int N_SIG      = N_DED + N_FB;
  localparam int N_COL      = 2 * N_SIG;
  localparam int ROW_BITS   = N_COL + 1;
  localparam int N_SUM_ROWS = group_base(N_OUT, N_OUT, MIN_TERMS, TERM_STEP);
  localparam int CLR_ROW    = N_SUM_ROWS;
  localparam int SET_ROW    = N_SUM_ROWS + 1;
  localparam int N_ROWS     = N_SUM_ROWS + 2;
  localparam int CFG_BITS   = N_ROWS * ROW_BITS;

  logic [CFG_BITS-1:0] cfg_bits;
  logic [N_SIG-1:0]    sig;
  logic [N_ROWS-1:0]   row_term;
  logic [N_ROWS-1:0]   row_contra;
  logic [N_ROWS-1:0]   row_empty;
  logic [N_ROWS-1:0]   row_dis;

  assign sig = {in_fb, in_ded};

  pal_cfg_chain #(.LEN(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift_en),
    .sdi      (cfg_sdi),
    .bits     (cfg_bits)
  );

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign row_dis[r] = cfg_bits[r*ROW_BITS + N_COL];

    pal_pterm #(.N_SIG(N_SIG)) u_pt (
      .sig    (sig),
      .conn   (cfg_bits[r*ROW_BITS +: N_COL]),
      .dis    (row_dis[r]),
      .term   (row_term[r]),
      .contra (row_contra[r]),
      .empty  (row_empty[r])
    );

    // R6: a true/complement pair on one signal kills the row
    assert_contra_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      row_contra[r] |-> !row_term[r]);
    // R5: an enabled row with nothing connected is 1
    assert_empty_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (row_empty[r] && !row_dis[r]) |-> row_term[r]);
    // R7: a disabled row is 0
    assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      row_dis[r] |-> !row_term[r]);
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_sum
    localparam int BASE = group_base(k, N_OUT, MIN_TERMS, TERM_STEP);
    localparam int CNT  = group_terms(k, N_OUT, MIN_TERMS, TERM_STEP);

    pal_or_group #(.WIDTH(CNT)) u_or (
      .terms (row_term[BASE +: CNT]),
      .sum   (sum_out[k])
    );

    // R8: a sum whose rows are all disabled stays low
    assert_group_dead_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (&row_dis[BASE +: CNT]) |-> !sum_out[k]);
  end

  // R9: the two unsummed rows go straight to their pins
  assign clr_term = row_term[CLR_ROW];
  assign set_term = row_term[SET_ROW];

  // R1: first cycle out of reset sees an all-empty plane
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((&sum_out) && clr_term && set_term));

  // R10: idle chain and steady inputs give steady outputs
  assert_comb_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_shift_en && $past(!cfg_shift_en) && $stable(in_ded) && $stable(in_fb))
      |-> ($stable(sum_out) && $stable(clr_term) && $stable(set_term)));

endmodule

// File: tb/pal_sop_array_tb.sv
`timescale 1ns/1ps
module pal_sop_array_tb;

  localparam int NSIG  = 22;
  localparam int RB    = 45;
  localparam int NROWS = 122;
  localparam int TOT   = NROWS * RB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_shift_en = 1'b0;
  logic        cfg_sdi = 1'b0;
  logic [11:0] in_ded = '0;
  logic [9:0]  in_fb = '0;
  logic [9:0]  sum_out;
  logic        clr_term;
  logic        set_term;

  logic [TOT-1:0] img;
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pal_sop_array u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_sdi(cfg_sdi),
    .in_ded(in_ded), .in_fb(in_fb), .sum_out(sum_out),
    .clr_term(clr_term), .set_term(set_term)
  );

  function automatic int grp_cnt(input int k);
    int tbl [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
    return tbl[k];
  endfunction

  function automatic int grp_first(input int k);
    int a = 0;
    for (int j = 0; j < k; j++) a += grp_cnt(j);
    return a;
  endfunction

  function automatic bit m_term(input int row, input logic [11:0] d, input logic [9:0] f);
    bit t = 1'b1;
    bit v;
    for (int s = 0; s < NSIG; s++) begin
      v = (s < 12) ? d[s] : f[s-12];
      if (img[row*RB + 2*s] && !v) t = 1'b0;
      if (img[row*RB + 2*s + 1] && v) t = 1'b0;
    end
    if (img[row*RB + 44]) t = 1'b0;
    return t;
  endfunction

  function automatic logic [9:0] m_sums(input logic [11:0] d, input logic [9:0] f);
    logic [9:0] s = '0;
    for (int k = 0; k < 10; k++)
      for (int r = grp_first(k); r < grp_first(k) + grp_cnt(k); r++)
        if (m_term(r, d, f)) s[k] = 1'b1;
    return s;
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " sums R8"}, sum_out, m_sums(in_ded, in_fb));
    check({tag, " clr R9"}, {9'd0, clr_term}, {9'd0, m_term(120, in_ded, in_fb)});
    check({tag, " set R9"}, {9'd0, set_term}, {9'd0, m_term(121, in_ded, in_fb)});
  endtask

  task automatic load_image();
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk);
      cfg_shift_en = 1'b1;
      cfg_sdi = img[i];
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
  endtask

  task automatic vectors(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_ded = 12'($urandom);
      in_fb  = 10'($urandom);
      #1;
      check_all(tag);
    end
  endtask

  task automatic random_image(input int den);
    for (int i = 0; i < TOT; i++) img[i] = (($urandom % den) == 0);
    for (int r = 0; r < NROWS; r++) img[r*RB + 44] = (($urandom % 6) == 0);
  endtask

  initial begin
    int seed;
    int dens [4] = '{4, 9, 18, 35};
    seed = $urandom(32'd20240611);
    img = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, all rows empty and enabled
    check("R1 reset sums", sum_out, 10'h3FF);
    check("R1 reset ctrl", {8'd0, clr_term, set_term}, 10'h003);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", sum_out, 10'h3FF);

    // R7: every row disabled
    for (int r = 0; r < NROWS; r++) img[r*RB + 44] = 1'b1;
    load_image();
    vectors(10, "R7 all disabled");
    check("R7 sums zero", sum_out, 10'h000);
    check("R7 ctrl zero", {8'd0, clr_term, set_term}, 10'h000);

    // Directed pattern: R2 layout, R4 literals, R5, R6, R8 boundaries, R9
    img[0*RB + 44]   = 1'b0;                     // output 0 first row, empty
    img[29*RB + 44]  = 1'b0;                     // output 2 last row, empty
    img[119*RB + 44] = 1'b0;                     // output 9 last row, empty
    img[75*RB + 44]  = 1'b0;                     // output 5 last row
    img[75*RB + 6]   = 1'b1;                     // R6 signal 3 true
    img[75*RB + 7]   = 1'b1;                     // R6 signal 3 complement
    img[90*RB + 44]  = 1'b0;                     // output 7 first row
    img[90*RB + 24]  = 1'b1;                     // in_fb[0] true
    img[90*RB + 9]   = 1'b1;                     // in_ded[4] complement
    img[120*RB + 44] = 1'b0;
    img[120*RB + 0]  = 1'b1;                     // clr = in_ded[0]
    img[121*RB + 44] = 1'b0;
    img[121*RB + 43] = 1'b1;                     // set = ~in_fb[9]
    load_image();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      in_ded = 12'($urandom);
      in_fb  = 10'($urandom);
      #1;
      check("R5 R8 directed sums", sum_out,
            {2'b10, in_fb[0] & ~in_ded[4], 4'b0000, 3'b101});
      check("R9 R4 clr literal", {9'd0, clr_term}, {9'd0, in_ded[0]});
      check("R9 R4 set literal", {9'd0, set_term}, {9'd0, ~in_fb[9]});
    end
    check("R6 contra row", {9'd0, sum_out[5]}, 10'd0);

    // R10: combinational response with no clock edge in between
    @(negedge clk);
    in_fb[0] = 1'b1; in_ded[4] = 1'b0; #0.5;
    check("R10 rise", {9'd0, sum_out[7]}, 10'd1);
    in_ded[4] = 1'b1; #0.5;
    check("R10 fall", {9'd0, sum_out[7]}, 10'd0);

    // Random patterns of varying density, R3 idle stretch after each
    for (int p = 0; p < 6; p++) begin
      random_image(dens[p % 4]);
      load_image();
      vectors(40, "R4 random");
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        cfg_sdi = 1'($urandom);
      end
      vectors(20, "R3 idle hold");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(4 * 195000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule